// File: doc/BRIEF.md
# Stacked register frame mapper

This block turns logical general register numbers into physical indices of a 128-entry register file. Each entry holds 64 data bits and a NaT bit. The low 32 logical registers are global and always map to themselves. Logical registers from 32 upward are relative to a movable frame base, which walks around a 96-entry circular stack of physical registers. A procedure call issues an alloc with the size of the new frame. The new frame opens just above the caller's frame, and the caller's registers are kept in place. A return issues a dealloc, which brings back the caller's base and size from a 16-deep stack of saved frame sizes.

When a new frame does not fit beside the registers of the callers that are still held, the block spills the oldest held registers. It moves one register per handshake to a backing-store port, writing upward from address 0. On a return to a frame whose lower registers were spilled, it reads them back in reverse order. While any transfer is in progress, the block reports busy and ignores commands and register writes. The block also contains the register file, with one read port and one write port addressed by logical number.

Top module: `stacked_frame_mapper`

## Requirements
- R1: After reset the frame base is 0, the frame size is 0, busy is 0 and no memory request is raised.
- R2: Logical registers 0 to 31 map to physical registers 0 to 31 under every frame state.
- R3: A logical register L of 32 or more maps to physical 32 + ((base + L - 32) mod 96).
- R4: Logical register 0 reads data 0 with NaT 0, and writes to it have no effect.
- R5: A logical register L of 32 or more with L - 32 >= frame size raises rd_illegal on the read port. A write to such a register is dropped.
- R6: An accepted alloc of n sets the base to (base + old size) mod 96 and the size to n. An alloc with n > 96, or with 16 sizes already saved, is ignored. If both commands arrive together, alloc wins.
- R7: A dealloc restores the caller's size and sets the base to (base - caller size) mod 96. A dealloc with no saved size is ignored.
- R8: Suppose held caller registers plus the new frame exceed 96. The block then spills exactly the excess, oldest first, with mem_we = 1. Addresses run upward from a backing count that starts at 0. mem_wdata carries the NaT in bit 64 above the 64 data bits.
- R9: Suppose a dealloc returns to a frame with k registers missing. The block fills exactly k, with mem_we = 0. Addresses run downward from the last spilled address, and the NaT in bit 64 is restored.
- R10: Busy is high from the cycle after an alloc or dealloc that needs transfers until the last acknowledge. While busy, commands and register writes are ignored, and a request holds its address and direction until it is acknowledged.
- R11: A value written to a register in a frame reads back unchanged, NaT included, after any sequence of nested allocs and deallocs that returns to that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_alloc | input | 1 | Open a new frame of cmd_size registers |
| cmd_dealloc | input | 1 | Release the current frame and return to the caller |
| cmd_size | input | 7 | Size of the new frame for alloc |
| rd_lreg | input | 7 | Logical register to read |
| rd_phys | output | 7 | Physical index of rd_lreg |
| rd_data | output | 64 | Read data |
| rd_nat | output | 1 | Read NaT bit |
| rd_illegal | output | 1 | rd_lreg lies beyond the current frame |
| wr_en | input | 1 | Write strobe |
| wr_lreg | input | 7 | Logical register to write |
| wr_data | input | 64 | Write data |
| wr_nat | input | 1 | Write NaT bit |
| busy | output | 1 | Spill or fill in progress |
| frame_base | output | 7 | Ring position of logical register 32 |
| frame_size | output | 7 | Current frame size |
| mem_req | output | 1 | Backing-store transfer request |
| mem_we | output | 1 | 1 for spill (write), 0 for fill (read) |
| mem_addr | output | 11 | Backing-store register slot |
| mem_wdata | output | 65 | Spilled value, NaT in the top bit |
| mem_rdata | input | 65 | Filled value, NaT in the top bit |
| mem_ack | input | 1 | Transfer accepted this cycle |

## Verification
Suppose the held-register count goes wrong. The first visible sign is the number of spill or fill beats after the next alloc or dealloc, or a wrong backing address on the very first beat. Both are compared on every beat. Suppose instead that a slot is computed wrongly. This shows on rd_phys at once. It may also show many calls later as a corrupted value when a caller's frame is read back after a fill, so the randomized call and return walk reads saved values back at every return. A write that slips through while busy, or a write dropped beyond the frame, leaves no immediate mark. It is exposed by a later read of the register it would have touched.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_SPILL, ST_FILL} xfer_st_e;

  // v mod n for v in a small signed range
  function automatic int ring_wrap(input int v, input int n);
    int r;
    r = v % n;
    if (r < 0) r = r + n;
    return r;
  endfunction

  // logical -> physical register index
  function automatic int map_phys(input int lreg, input int base, input int nfix, input int nstk);
    if (lreg < nfix) return lreg;
    return nfix + ring_wrap(base + lreg - nfix, nstk);
  endfunction

  // stacked register outside the live frame
  function automatic bit out_of_frame(input int lreg, input int size, input int nfix);
    return (lreg >= nfix) && (lreg - nfix >= size);
  endfunction

endpackage

// File: rtl/rsm_marker_stack.sv
module rsm_marker_stack #(
  parameter int DEPTH = 16,
  parameter int W     = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic [W-1:0]  slots [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full    = (int'(cnt_q) == DEPTH);
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !push && !empty;
  assign top     = empty ? '0 : slots[IW'(cnt_q - CW'(1))];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (do_push) cnt_q <= cnt_q + CW'(1);
    else if (do_pop)  cnt_q <= cnt_q - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (do_push) slots[IW'(cnt_q)] <= din;
  end

  assert_depth_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> !(int'(cnt_q) > DEPTH));

endmodule

// File: rtl/rsm_frame_ctrl.sv
module rsm_frame_ctrl
  import rsm_pkg::*;
#(
  parameter int NFIX   = 32,
  parameter int NSTK   = 96,
  parameter int MDEPTH = 16,
  parameter int AW     = 11,
  parameter int SW     = 7,
  parameter int PW     = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_alloc,
  input  logic          cmd_dealloc,
  input  logic [SW-1:0] cmd_size,
  input  logic          mem_ack,
  output logic [SW-1:0] frame_base,
  output logic [SW-1:0] frame_size,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [PW-1:0] xfer_phys,
  output logic          fill_beat
);
  xfer_st_e      state_q;
  logic [SW-1:0] base_q, size_q, dirty_q, left_q;
  logic [AW-1:0] cnt_q;
  logic [SW-1:0] stk_top;
  logic          stk_full, stk_empty;

  // named events
  logic idle, alloc_ok, dealloc_ok, spill_beat;
  int   slot;

  assign idle       = (state_q == ST_IDLE);
  assign alloc_ok   = cmd_alloc && idle && (int'(cmd_size) <= NSTK) && !stk_full;
  assign dealloc_ok = cmd_dealloc && !cmd_alloc && idle && !stk_empty;
  assign spill_beat = (state_q == ST_SPILL) && mem_ack;
  assign fill_beat  = (state_q == ST_FILL) && mem_ack;

  assign busy       = !idle;
  assign mem_req    = !idle;
  assign mem_we     = (state_q == ST_SPILL);
  assign mem_addr   = (state_q == ST_FILL) ? cnt_q - AW'(1) : cnt_q;
  assign frame_base = base_q;
  assign frame_size = size_q;

  always_comb begin
    if (state_q == ST_FILL) slot = ring_wrap(int'(base_q) + int'(left_q) - 1, NSTK);
    else                    slot = ring_wrap(int'(base_q) - int'(dirty_q), NSTK);
  end
  assign xfer_phys = PW'(NFIX + slot);

  rsm_marker_stack #(.DEPTH(MDEPTH), .W(SW)) i_marks (
    .clk(clk), .rst_n(rst_n), .push(alloc_ok), .pop(dealloc_ok),
    .din(size_q), .top(stk_top), .full(stk_full), .empty(stk_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      size_q  <= '0;
      dirty_q <= '0;
      left_q  <= '0;
      cnt_q   <= '0;
    end else if (alloc_ok) begin
      base_q  <= SW'(ring_wrap(int'(base_q) + int'(size_q), NSTK));
      size_q  <= cmd_size;
      dirty_q <= dirty_q + size_q;
      state_q <= (int'(dirty_q) + int'(size_q) + int'(cmd_size) > NSTK) ? ST_SPILL : ST_IDLE;
    end else if (dealloc_ok) begin
      base_q <= SW'(ring_wrap(int'(base_q) - int'(stk_top), NSTK));
      size_q <= stk_top;
      if (dirty_q >= stk_top) begin
        dirty_q <= dirty_q - stk_top;
      end else begin
        dirty_q <= '0;
        left_q  <= stk_top - dirty_q;
        state_q <= ST_FILL;
      end
    end else if (spill_beat) begin
      dirty_q <= dirty_q - SW'(1);
      cnt_q   <= cnt_q + AW'(1);
      if (int'(dirty_q) - 1 + int'(size_q) <= NSTK) state_q <= ST_IDLE;
    end else if (fill_beat) begin
      left_q <= left_q - SW'(1);
      cnt_q  <= cnt_q - AW'(1);
      if (left_q == SW'(1)) state_q <= ST_IDLE;
    end
  end

  assert_ring_fits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (int'(dirty_q) + int'(size_q) <= NSTK));
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  assert_frame_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(frame_base) && $stable(frame_size)));
  assert_fill_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL) |-> (left_q != '0));

endmodule

// File: rtl/rsm_regfile.sv
module rsm_regfile #(
  parameter int NREGS = 128,
  parameter int EW    = 65,
  parameter int PW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [PW-1:0] ra,
  output logic [EW-1:0] rdata_a,
  input  logic [PW-1:0] rb,
  output logic [EW-1:0] rdata_b
);
  logic [EW-1:0] cells [NREGS];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata_a = (ra == '0) ? '0 : cells[ra];
  assign rdata_b = cells[rb];

  assert_zero_untouched_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (waddr != '0));

endmodule

// File: rtl/stacked_frame_mapper.sv
module stacked_frame_mapper
  import rsm_pkg::*;
#(
  parameter int NUM_REGS   = 128,
  parameter int NUM_FIXED  = 32,
  parameter int DW         = 64,
  parameter int MARK_DEPTH = 16,
  parameter int AW         = 11
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cmd_alloc,
  input  logic                                  cmd_dealloc,
  input  logic [$clog2(NUM_REGS-NUM_FIXED+1)-1:0] cmd_size,
  input  logic [$clog2(NUM_REGS)-1:0]           rd_lreg,
  output logic [$clog2(NUM_REGS)-1:0]           rd_phys,
  output logic [DW-1:0]                         rd_data,
  output logic                                  rd_nat,
  output logic                                  rd_illegal,
  input  logic                                  wr_en,
  input  logic [$clog2(NUM_REGS)-1:0]           wr_lreg,
  input  logic [DW-1:0]                         wr_data,
  input  logic                                  wr_nat,
  output logic                                  busy,
  output logic [$clog2(NUM_REGS-NUM_FIXED+1)-1:0] frame_base,
  output logic [$clog2(NUM_REGS-NUM_FIXED+1)-1:0] frame_size,
  output logic                                  mem_req,
  output logic                                  mem_we,
  output logic [AW-1:0]                         mem_addr,
  output logic [DW:0]                           mem_wdata,
  input  logic [DW:0]                           mem_rdata,
  input  logic                                  mem_ack
);
  localparam int NSTK = NUM_REGS - NUM_FIXED;
  localparam int SW   = $clog2(NSTK + 1);
  localparam int PW   = $clog2(NUM_REGS);

  logic [PW-1:0] wr_phys, xfer_phys, rf_waddr;
  logic [DW:0]   rf_rdata, rf_wdata;
  logic          fill_beat, wr_illegal, wr_ok, rf_we;

  rsm_frame_ctrl #(
    .NFIX(NUM_FIXED), .NSTK(NSTK), .MDEPTH(MARK_DEPTH), .AW(AW), .SW(SW), .PW(PW)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_alloc(cmd_alloc), .cmd_dealloc(cmd_dealloc),
    .cmd_size(cmd_size), .mem_ack(mem_ack), .frame_base(frame_base),
    .frame_size(frame_size), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .xfer_phys(xfer_phys), .fill_beat(fill_beat)
  );

  assign rd_phys    = PW'(map_phys(int'(rd_lreg), int'(frame_base), NUM_FIXED, NSTK));
  assign wr_phys    = PW'(map_phys(int'(wr_lreg), int'(frame_base), NUM_FIXED, NSTK));
  assign rd_illegal = out_of_frame(int'(rd_lreg), int'(frame_size), NUM_FIXED);
  assign wr_illegal = out_of_frame(int'(wr_lreg), int'(frame_size), NUM_FIXED);
  assign wr_ok      = wr_en && !busy && !wr_illegal && (wr_lreg != '0);

  assign rf_we    = fill_beat || wr_ok;
  assign rf_waddr = fill_beat ? xfer_phys : wr_phys;
  assign rf_wdata = fill_beat ? mem_rdata : {wr_nat, wr_data};

  rsm_regfile #(.NREGS(NUM_REGS), .EW(DW + 1), .PW(PW)) i_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra(rd_phys), .rdata_a(rf_rdata), .rb(xfer_phys), .rdata_b(mem_wdata)
  );

  assign rd_data = rf_rdata[DW-1:0];
  assign rd_nat  = rf_rdata[DW];

  assert_fixed_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_lreg) < NUM_FIXED) |-> (rd_phys == rd_lreg));
  assert_stacked_ring_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_lreg) >= NUM_FIXED) |-> (int'(rd_phys) >= NUM_FIXED));
  assert_spill_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (int'(xfer_phys) >= NUM_FIXED));
  assert_no_write_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_we) |-> !rf_we);

endmodule

// File: tb/test_stacked_frame_mapper.sv
module test_stacked_frame_mapper;
  localparam int DW = 64, NF = 32, NS = 96, MD = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cmd_alloc, cmd_dealloc, wr_en, wr_nat, rd_nat, rd_illegal, busy;
  logic mem_req, mem_we, mem_ack;
  logic [6:0] cmd_size, rd_lreg, rd_phys, wr_lreg, frame_base, frame_size;
  logic [DW-1:0] wr_data, rd_data;
  logic [10:0] mem_addr;
  logic [DW:0] mem_wdata, mem_rdata;

  stacked_frame_mapper i_stacked_frame_mapper (
    .clk(clk), .rst_n(rst_n), .cmd_alloc(cmd_alloc), .cmd_dealloc(cmd_dealloc),
    .cmd_size(cmd_size), .rd_lreg(rd_lreg), .rd_phys(rd_phys), .rd_data(rd_data),
    .rd_nat(rd_nat), .rd_illegal(rd_illegal), .wr_en(wr_en), .wr_lreg(wr_lreg),
    .wr_data(wr_data), .wr_nat(wr_nat), .busy(busy), .frame_base(frame_base),
    .frame_size(frame_size), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int n_cmp = 0, n_bad = 0;
  int m_base = 0, m_size = 0, m_dirty = 0, m_depth = 0, e_cnt = 0, m_cnt = 0;
  int stk [MD];
  logic [DW:0] bmem [2048];
  logic [DW:0] shadow [MD+1][NS];
  bit          sval   [MD+1][NS];
  logic [DW:0] fshadow [NF];
  bit          fval    [NF];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [DW:0] act, input logic [DW:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [DW:0] rnd65();
    return {$urandom, $urandom, $urandom};
  endfunction

  function automatic int exp_phys(input int l);
    return (l < NF) ? l : NF + ((m_base + l - NF) % NS);
  endfunction

  // backing store model with random acknowledge delay; checks R8/R9 addressing
  initial begin
    mem_ack = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req && ($urandom % 3 != 0)) begin
        if (mem_we) begin
          chk(int'(mem_addr) == m_cnt, "R8", "spill address", 65'(mem_addr), 65'(m_cnt));
          bmem[mem_addr] = mem_wdata;
          m_cnt++;
        end else begin
          chk(int'(mem_addr) == m_cnt - 1, "R9", "fill address", 65'(mem_addr), 65'(m_cnt - 1));
          mem_rdata = bmem[mem_addr];
          m_cnt--;
        end
        mem_ack = 1'b1;
      end
    end
  end

  task automatic frame_chk(input string rq);
    chk(int'(frame_base) == m_base, rq, "frame base", 65'(frame_base), 65'(m_base));
    chk(int'(frame_size) == m_size, rq, "frame size", 65'(frame_size), 65'(m_size));
    chk(m_cnt == e_cnt, rq, "transfer count", 65'(m_cnt), 65'(e_cnt));
  endtask

  task automatic poke_while_busy();
    cmd_dealloc = 1'b1; cmd_alloc = 1'b0; wr_en = 1'b1; wr_lreg = 7'd5;
    {wr_nat, wr_data} = ~fshadow[5];
    @(negedge clk);
    cmd_dealloc = 1'b0; wr_en = 1'b0;
  endtask

  task automatic do_alloc(input int n, input bit poke);
    bit take;
    int need;
    @(negedge clk);
    cmd_alloc = 1'b1; cmd_size = 7'(n);
    take = (n <= NS) && (m_depth < MD);
    need = 0;
    if (take) begin
      stk[m_depth] = m_size;
      m_dirty += m_size;
      m_base = (m_base + m_size) % NS;
      m_size = n;
      m_depth++;
      for (int i = 0; i < NS; i++) sval[m_depth][i] = 1'b0;
      if (m_dirty + m_size > NS) begin
        need = m_dirty + m_size - NS;
        m_dirty -= need;
        e_cnt += need;
      end
    end
    @(negedge clk);
    cmd_alloc = 1'b0;
    chk(busy == (need > 0), "R10", "busy after alloc", 65'(busy), 65'(need > 0));
    if (poke && busy) poke_while_busy();
    while (busy) @(negedge clk);
    frame_chk(take ? "R6" : "R6 ignored");
  endtask

  task automatic do_dealloc(input bit poke);
    bit take;
    int cs, need;
    @(negedge clk);
    cmd_dealloc = 1'b1;
    take = (m_depth > 0);
    need = 0;
    if (take) begin
      m_depth--;
      cs = stk[m_depth];
      m_base = (m_base - cs + NS) % NS;
      m_size = cs;
      if (m_dirty >= cs) m_dirty -= cs;
      else begin need = cs - m_dirty; m_dirty = 0; e_cnt -= need; end
    end
    @(negedge clk);
    cmd_dealloc = 1'b0;
    chk(busy == (need > 0), "R10", "busy after dealloc", 65'(busy), 65'(need > 0));
    if (poke && busy) poke_while_busy();
    while (busy) @(negedge clk);
    frame_chk(take ? (need > 0 ? "R9" : "R7") : "R7 ignored");
  endtask

  task automatic do_wr(input int l, input logic [DW:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_lreg = 7'(l); {wr_nat, wr_data} = v;
    @(negedge clk);
    wr_en = 1'b0;
    if (l > 0 && l < NF) begin fshadow[l] = v; fval[l] = 1'b1; end
    else if (l >= NF && l - NF < m_size) begin
      shadow[m_depth][l - NF] = v; sval[m_depth][l - NF] = 1'b1;
    end
  endtask

  task automatic rd_chk(input int l);
    bit ill;
    @(negedge clk);
    rd_lreg = 7'(l);
    #1;
    ill = (l >= NF) && (l - NF >= m_size);
    chk(int'(rd_phys) == exp_phys(l), (l < NF) ? "R2" : "R3", "phys map",
        65'(rd_phys), 65'(exp_phys(l)));
    chk(rd_illegal == ill, "R5", "illegal flag", 65'(rd_illegal), 65'(ill));
    if (l == 0)
      chk({rd_nat, rd_data} == '0, "R4", "reg0 read", {rd_nat, rd_data}, '0);
    else if (l < NF && fval[l])
      chk({rd_nat, rd_data} == fshadow[l], "R11", "fixed data", {rd_nat, rd_data}, fshadow[l]);
    else if (!ill && l >= NF && sval[m_depth][l - NF])
      chk({rd_nat, rd_data} == shadow[m_depth][l - NF], "R11", "frame data",
          {rd_nat, rd_data}, shadow[m_depth][l - NF]);
  endtask

  task automatic fill_frame();
    for (int i = 0; i < m_size; i++) do_wr(NF + i, rnd65());
  endtask

  task automatic read_frame();
    for (int i = 0; i < m_size; i++) rd_chk(NF + i);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog expired: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [DW:0] cval;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < NF; i++) fval[i] = 1'b0;
    for (int d = 0; d <= MD; d++) for (int i = 0; i < NS; i++) sval[d][i] = 1'b0;
    rst_n = 1'b0; cmd_alloc = 0; cmd_dealloc = 0; cmd_size = '0; rd_lreg = '0;
    wr_en = 0; wr_lreg = '0; wr_data = '0; wr_nat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy", 65'(busy), 65'(0));
    chk(mem_req == 1'b0, "R1", "mem_req", 65'(mem_req), 65'(0));
    chk(frame_base == '0, "R1", "base", 65'(frame_base), 65'(0));
    chk(frame_size == '0, "R1", "size", 65'(frame_size), 65'(0));

    // R2 / R4: fixed registers and register 0
    for (int i = 1; i < NF; i++) do_wr(i, rnd65());
    do_wr(0, {1'b1, 64'hdead_beef_0000_0001});
    rd_chk(0);
    rd_chk(5);
    rd_chk(40);        // R5 empty frame: every stacked register is illegal
    do_dealloc(1'b0);  // R7 nothing saved: ignored

    // R5 dropped write beyond the frame
    do_alloc(4, 1'b0);
    do_alloc(4, 1'b0);
    cval = rnd65();
    do_wr(32, cval);
    rd_chk(32);
    do_dealloc(1'b0);
    do_wr(36, ~cval);  // slot of the callee's logical 32, but outside this frame
    do_alloc(4, 1'b0);
    @(negedge clk); rd_lreg = 7'd32; #1;
    chk({rd_nat, rd_data} == cval, "R5", "write beyond frame dropped", {rd_nat, rd_data}, cval);
    do_dealloc(1'b0);
    do_dealloc(1'b0);

    // R8/R9/R11 deep spill and fill, busy pokes for R10
    do_alloc(97, 1'b0);        // R6 oversize ignored
    do_alloc(60, 1'b0); fill_frame();
    do_alloc(60, 1'b1); fill_frame();
    do_alloc(96, 1'b1); fill_frame();
    do_alloc(0, 1'b0);
    do_dealloc(1'b1); read_frame();
    do_dealloc(1'b1); read_frame();
    do_dealloc(1'b1); read_frame();
    do_dealloc(1'b0);
    rd_chk(5);                 // R10 poked writes must not land

    // R6 saved-size stack full
    for (int k = 0; k < MD; k++) begin do_alloc(7, 1'b0); fill_frame(); end
    do_alloc(3, 1'b0);         // 17th: ignored
    for (int k = 0; k < MD; k++) begin read_frame(); do_dealloc(1'b1); end
    read_frame();

    // random walk of calls, returns, reads and writes
    for (int op = 0; op < 400; op++) begin
      int sel;
      sel = $urandom % 10;
      if (sel < 2) begin
        int n;
        n = ($urandom % 16 == 0) ? 90 + ($urandom % 10) : $urandom % 48;
        do_alloc(n, $urandom % 2);
        if ($urandom % 2 == 0) fill_frame();
      end else if (sel < 4) begin
        do_dealloc($urandom % 2);
        read_frame();
      end else if (sel < 7) begin
        do_wr($urandom % 128, rnd65());
      end else begin
        rd_chk($urandom % 128);
      end
    end
    while (m_depth > 0) begin do_dealloc(1'b0); read_frame(); end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule